// File: doc/BRIEF.md
# Wave Divergence Mask Controller

This block steers one wave of threads that share a single instruction stream. It holds the execution mask: one bit per thread, where a set bit means that thread's ALU lane does work. When the instruction stream reaches structured control flow, the block receives an event code and a vector with one condition bit per thread. It narrows, swaps or restores the mask from these. When no thread needs a region of code, it tells the fetch unit to jump over that region. At the bottom of a loop it tells the fetch unit to jump back.

For a conditional, the mask that encloses it is pushed onto a small stack, so conditionals can nest. If all active threads agree, one side is never issued: its mask comes out empty and the block raises `skip`. If the threads disagree, the two sides run one after the other under complementary masks. A loop keeps running while any thread still active wants another pass. A thread that drops out stays masked until the loop exits, and then the enclosing mask comes back. Every output is registered and shows the effect of an event in the cycle after the clock edge that accepts it.

Top module: `wave_mask_ctrl`

## Requirements
- R1: After reset the mask is all ones, depth is 0, and `err`, `skip` and `jump` are 0.
- R2: Event code 1 (branch) pushes the current mask and its else mask (current AND NOT cond) onto the stack. The new mask is current AND cond, and depth rises by one. All of this is visible the cycle after the event.
- R3: A branch where no active thread has its condition bit set gives an all-zero mask and a one-cycle `skip`.
- R4: Event code 2 (else) loads the stored else mask (enclosing AND NOT cond). If that mask is zero, meaning every active thread took the first side, `skip` pulses.
- R5: Event code 3 (end-if) pops the stack, restores the enclosing mask and lowers depth by one.
- R6: Conditionals nest to DEPTH levels, and each end-if restores its own level's mask in reverse order.
- R7: Event code 4 (loop test) entered fresh pushes the current mask and sets mask = current AND cond. After event code 5 (loop end), which pulses `jump`, the next loop test ANDs cond into the surviving mask only. A thread that has left the loop stays off even if its cond bit returns to 1.
- R8: A loop test that leaves no active thread pulses `skip`, restores the mask that was current when the loop was entered, and leaves depth as it was before entry.
- R9: A push with depth = DEPTH, or an else, end-if or loop end with depth 0, sets `err`. `err` stays set until reset, and that event leaves mask and depth unchanged and raises no `jump`.
- R10: With `ev_valid` low, or with event codes 0, 6 or 7, nothing changes.
- R11: `skip` and `jump` are single-cycle pulses, are never high together, and are 0 in any cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | An event is offered this cycle |
| ev_kind | input | 3 | Event code: 1 branch, 2 else, 3 end-if, 4 loop test, 5 loop end |
| ev_cond | input | THREADS | Per-thread condition bits |
| exec_mask | output | THREADS | Current execution mask |
| skip | output | 1 | Region ahead has no active thread; fetch jumps over it |
| jump | output | 1 | Loop end: fetch returns to the loop test |
| depth | output | $clog2(DEPTH+1) | Stack occupancy |
| err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The hardest state to reach is a loop that is re-entered after a jump while some threads have already dropped out. That is the only case where the stored loop context must not be pushed again and the incoming condition bits must be ignored for retired threads. The stimulus table runs a loop for three passes. On each pass the condition vector sets the high thread bits that had left earlier, so a design that re-admitted them would show extra mask bits. Exit then has to restore the full enclosing mask. A second path fills the stack to its limit, pushes once more, and unwinds one level past empty to reach both error conditions.

// File: rtl/wmc_pkg.sv
package wmc_pkg;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_IF    = 3'd1,
    EV_ELSE  = 3'd2,
    EV_ENDIF = 3'd3,
    EV_LTEST = 3'd4,
    EV_LEND  = 3'd5
  } ev_kind_e;

endpackage

// File: rtl/wmc_mask_stack.sv
module wmc_mask_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  push_parent,
  input  logic [W-1:0]  push_else,
  output logic [W-1:0]  top_parent,
  output logic [W-1:0]  top_else,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [CW-1:0] count_q, count_d;
  logic [W-1:0]  ent_par [DEPTH];
  logic [W-1:0]  ent_els [DEPTH];

  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));
  assign count = count_q;

  // next-state for occupancy
  always_comb begin
    count_d = count_q;
    if (push && !pop)
      count_d = count_q + CW'(1);
    else if (pop && !push)
      count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (push || pop)
      count_q <= count_d;
  end

  // one register pair per stack level, written only on a push into that level
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] par_q;
    logic [W-1:0] els_q;
    logic         wr_en;

    assign wr_en = push && (count_q == CW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        par_q <= '0;
        els_q <= '0;
      end else if (wr_en) begin
        par_q <= push_parent;
        els_q <= push_else;
      end
    end

    assign ent_par[i] = par_q;
    assign ent_els[i] = els_q;
  end

  // top-of-stack read mux
  always_comb begin
    top_parent = '0;
    top_else   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count_q == CW'(i + 1)) begin
        top_parent = ent_par[i];
        top_else   = ent_els[i];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R9
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R9

endmodule

// File: rtl/wmc_branch_logic.sv
module wmc_branch_logic
  import wmc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         ev_valid,
  input  logic [2:0]   ev_kind,
  input  logic [W-1:0] cond,
  input  logic [W-1:0] exec,
  input  logic [W-1:0] top_parent,
  input  logic [W-1:0] top_else,
  input  logic         empty,
  input  logic         full,
  input  logic         rearm,
  output logic [W-1:0] exec_d,
  output logic         push,
  output logic         pop,
  output logic [W-1:0] push_parent,
  output logic [W-1:0] push_else,
  output logic         skip_d,
  output logic         jump_d,
  output logic         rearm_d,
  output logic         err_set
);

  logic [W-1:0] taken;
  logic [W-1:0] not_taken;

  assign taken     = exec & cond;
  assign not_taken = exec & ~cond;

  always_comb begin
    exec_d      = exec;
    push        = 1'b0;
    pop         = 1'b0;
    push_parent = exec;
    push_else   = not_taken;
    skip_d      = 1'b0;
    jump_d      = 1'b0;
    rearm_d     = ev_valid ? 1'b0 : rearm;
    err_set     = 1'b0;
    if (ev_valid) begin
      unique case (ev_kind_e'(ev_kind))
        EV_IF: begin
          if (full) begin
            err_set = 1'b1;
          end else begin
            push   = 1'b1;
            exec_d = taken;
            skip_d = (taken == '0);
          end
        end
        EV_ELSE: begin
          if (empty) begin
            err_set = 1'b1;
          end else begin
            exec_d = top_else;
            skip_d = (top_else == '0);
          end
        end
        EV_ENDIF: begin
          if (empty) begin
            err_set = 1'b1;
          end else begin
            pop    = 1'b1;
            exec_d = top_parent;
          end
        end
        EV_LTEST: begin
          if (rearm) begin
            // returning pass: context already stacked
            if (empty) begin
              err_set = 1'b1;
            end else if (taken == '0) begin
              pop    = 1'b1;
              exec_d = top_parent;
              skip_d = 1'b1;
            end else begin
              exec_d = taken;
            end
          end else begin
            // first pass: stack the enclosing mask
            if (full) begin
              err_set = 1'b1;
            end else if (taken == '0) begin
              skip_d = 1'b1;
            end else begin
              push      = 1'b1;
              push_else = '0;
              exec_d    = taken;
            end
          end
        end
        EV_LEND: begin
          if (empty) begin
            err_set = 1'b1;
          end else begin
            jump_d  = 1'b1;
            rearm_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wave_mask_ctrl.sv
module wave_mask_ctrl
  import wmc_pkg::*;
#(
  parameter int THREADS = 32,
  parameter int DEPTH   = 4,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [2:0]         ev_kind,
  input  logic [THREADS-1:0] ev_cond,
  output logic [THREADS-1:0] exec_mask,
  output logic               skip,
  output logic               jump,
  output logic [CW-1:0]      depth,
  output logic               err
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [THREADS-1:0] exec_q, exec_d;
  logic               skip_q, skip_d;
  logic               jump_q, jump_d;
  logic               err_q,  err_set;
  logic               rearm_q, rearm_d;
  logic               push, pop, empty, full;
  logic [THREADS-1:0] push_parent, push_else, top_parent, top_else;
  logic [CW-1:0]      count;
  logic               exec_en;

  wmc_mask_stack #(.W(THREADS), .DEPTH(DEPTH)) stack_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .push        (push),
    .pop         (pop),
    .push_parent (push_parent),
    .push_else   (push_else),
    .top_parent  (top_parent),
    .top_else    (top_else),
    .empty       (empty),
    .full        (full),
    .count       (count)
  );

  wmc_branch_logic #(.W(THREADS)) logic_i (
    .ev_valid    (ev_valid),
    .ev_kind     (ev_kind),
    .cond        (ev_cond),
    .exec        (exec_q),
    .top_parent  (top_parent),
    .top_else    (top_else),
    .empty       (empty),
    .full        (full),
    .rearm       (rearm_q),
    .exec_d      (exec_d),
    .push        (push),
    .pop         (pop),
    .push_parent (push_parent),
    .push_else   (push_else),
    .skip_d      (skip_d),
    .jump_d      (jump_d),
    .rearm_d     (rearm_d),
    .err_set     (err_set)
  );

  assign exec_en = ev_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      exec_q <= '1;
    else if (exec_en)
      exec_q <= exec_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      skip_q  <= 1'b0;
      jump_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      skip_q  <= skip_d;
      jump_q  <= jump_d;
      rearm_q <= rearm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)
      err_q <= 1'b0;
    else if (err_set)
      err_q <= 1'b1;
  end

  assign exec_mask = exec_q;
  assign skip      = skip_q;
  assign jump      = jump_q;
  assign depth     = count;
  assign err       = err_q;

  AST_IF_NARROWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_valid && ev_kind == 3'd1 && depth != CW'(DEPTH))
      |=> ((exec_mask & ~$past(exec_mask)) == '0)); // R2
  AST_IF_SKIP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_valid && ev_kind == 3'd1 && depth != CW'(DEPTH) && (exec_mask & ev_cond) == '0)
      |=> skip); // R3
  AST_ENDIF_POPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_valid && ev_kind == 3'd3 && depth != '0)
      |=> (depth == $past(depth) - CW'(1))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    err |=> err); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(skip && jump)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ev_valid |=> (!skip && !jump && $stable(exec_mask) && $stable(depth))); // R10

endmodule

// File: tb/wave_mask_ctrl_tb_top.sv
module wave_mask_ctrl_tb_top;

  localparam int TH = 32;
  localparam int DP = 4;
  localparam int NV = 30;

  typedef struct packed {
    logic [3:0]    req;
    logic [2:0]    kind;
    logic [TH-1:0] cond;
    logic [TH-1:0] mask;
    logic          skp;
    logic          jmp;
    logic [2:0]    dep;
    logic          er;
  } vec_t;

  // expected values worked out by hand from the requirements
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'd1, 32'h0000FFFF, 32'h0000FFFF, 1'b0, 1'b0, 3'd1, 1'b0}, // R2
    '{4'd2,  3'd1, 32'h00FF00FF, 32'h000000FF, 1'b0, 1'b0, 3'd2, 1'b0}, // R2 nested
    '{4'd4,  3'd2, 32'h00000000, 32'h0000FF00, 1'b0, 1'b0, 3'd2, 1'b0}, // R4 divergent else
    '{4'd5,  3'd3, 32'h00000000, 32'h0000FFFF, 1'b0, 1'b0, 3'd1, 1'b0}, // R5
    '{4'd3,  3'd1, 32'hFFFF0000, 32'h00000000, 1'b1, 1'b0, 3'd2, 1'b0}, // R3 uniform false
    '{4'd4,  3'd2, 32'h00000000, 32'h0000FFFF, 1'b0, 1'b0, 3'd2, 1'b0}, // R4
    '{4'd5,  3'd3, 32'h00000000, 32'h0000FFFF, 1'b0, 1'b0, 3'd1, 1'b0}, // R5
    '{4'd2,  3'd1, 32'h0000FFFF, 32'h0000FFFF, 1'b0, 1'b0, 3'd2, 1'b0}, // R2 uniform true
    '{4'd4,  3'd2, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 3'd2, 1'b0}, // R4 else skipped
    '{4'd5,  3'd3, 32'h00000000, 32'h0000FFFF, 1'b0, 1'b0, 3'd1, 1'b0}, // R5
    '{4'd5,  3'd3, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd0, 1'b0}, // R5
    '{4'd7,  3'd4, 32'h0000000F, 32'h0000000F, 1'b0, 1'b0, 3'd1, 1'b0}, // R7 loop entry
    '{4'd7,  3'd5, 32'h00000000, 32'h0000000F, 1'b0, 1'b1, 3'd1, 1'b0}, // R7 jump back
    '{4'd7,  3'd4, 32'hFFFFFFF3, 32'h00000003, 1'b0, 1'b0, 3'd1, 1'b0}, // R7 retired stay off
    '{4'd7,  3'd5, 32'h00000000, 32'h00000003, 1'b0, 1'b1, 3'd1, 1'b0}, // R7
    '{4'd7,  3'd4, 32'hFFFFFFFE, 32'h00000002, 1'b0, 1'b0, 3'd1, 1'b0}, // R7
    '{4'd7,  3'd5, 32'h00000000, 32'h00000002, 1'b0, 1'b1, 3'd1, 1'b0}, // R7
    '{4'd8,  3'd4, 32'hFFFFFFFD, 32'hFFFFFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R8 exit restores
    '{4'd10, 3'd6, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd0, 1'b0}, // R10 unused code
    '{4'd8,  3'd4, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 3'd0, 1'b0}, // R8 zero-trip loop
    '{4'd6,  3'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, 3'd1, 1'b0}, // R6
    '{4'd6,  3'd1, 32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0, 1'b0, 3'd2, 1'b0}, // R6
    '{4'd6,  3'd1, 32'h1FFFFFFF, 32'h1FFFFFFF, 1'b0, 1'b0, 3'd3, 1'b0}, // R6
    '{4'd6,  3'd1, 32'h0FFFFFFF, 32'h0FFFFFFF, 1'b0, 1'b0, 3'd4, 1'b0}, // R6 full
    '{4'd9,  3'd1, 32'h00000001, 32'h0FFFFFFF, 1'b0, 1'b0, 3'd4, 1'b1}, // R9 overflow
    '{4'd6,  3'd3, 32'h00000000, 32'h1FFFFFFF, 1'b0, 1'b0, 3'd3, 1'b1}, // R6
    '{4'd6,  3'd3, 32'h00000000, 32'h3FFFFFFF, 1'b0, 1'b0, 3'd2, 1'b1}, // R6
    '{4'd6,  3'd3, 32'h00000000, 32'h7FFFFFFF, 1'b0, 1'b0, 3'd1, 1'b1}, // R6
    '{4'd6,  3'd3, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd0, 1'b1}, // R6
    '{4'd9,  3'd3, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0, 3'd0, 1'b1}  // R9 underflow
  };

  logic          clk;
  logic          rst_n;
  logic          ev_valid;
  logic [2:0]    ev_kind;
  logic [TH-1:0] ev_cond;
  logic [TH-1:0] exec_mask;
  logic          skip;
  logic          jump;
  logic [2:0]    depth;
  logic          err;

  int n_chk;
  int n_fail;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  wave_mask_ctrl #(.THREADS(TH), .DEPTH(DP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ev_cond   (ev_cond),
    .exec_mask (exec_mask),
    .skip      (skip),
    .jump      (jump),
    .depth     (depth),
    .err       (err)
  );

  task automatic check(input string tag, input logic [TH-1:0] m, input logic s,
                       input logic j, input logic [2:0] d, input logic e);
    n_chk++;
    if (exec_mask !== m || skip !== s || jump !== j || depth !== d || err !== e) begin
      n_fail++;
      $display("FAIL %s: got mask=%h skip=%b jump=%b depth=%0d err=%b, expected mask=%h skip=%b jump=%b depth=%0d err=%b",
               tag, exec_mask, skip, jump, depth, err, m, s, j, d, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ev_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // offer one event; outputs are sampled at the next falling edge
  task automatic send(input logic [2:0] k, input logic [TH-1:0] c);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_kind  = k;
    ev_cond  = c;
    @(negedge clk);
    ev_valid = 1'b0;
    ev_kind  = 3'd0;
    ev_cond  = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    ev_valid = 1'b0;
    ev_kind = 3'd0;
    ev_cond = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '1, 1'b0, 1'b0, 3'd0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", '1, 1'b0, 1'b0, 3'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].kind, VEC[i].cond);
      check($sformatf("R%0d row %0d", VEC[i].req, i),
            VEC[i].mask, VEC[i].skp, VEC[i].jmp, VEC[i].dep, VEC[i].er);
    end

    // R1: reset clears the sticky error left by the table
    do_reset();
    check("R1 reset clears err", '1, 1'b0, 1'b0, 3'd0, 1'b0);

    // R10: branch code with valid low does nothing
    @(negedge clk);
    ev_kind = 3'd1;
    ev_cond = '0;
    @(negedge clk);
    ev_kind = 3'd0;
    check("R10 valid low", '1, 1'b0, 1'b0, 3'd0, 1'b0);

    // R9: else on empty stack
    send(3'd2, 32'h0);
    check("R9 else underflow", '1, 1'b0, 1'b0, 3'd0, 1'b1);
    do_reset();

    // R9: loop end on empty stack raises no jump
    send(3'd5, 32'h0);
    check("R9 loop end underflow", '1, 1'b0, 1'b0, 3'd0, 1'b1);
    do_reset();

    // R11: skip is a single pulse
    send(3'd1, 32'h0);
    check("R11 skip raised", 32'h0, 1'b1, 1'b0, 3'd1, 1'b0);
    @(negedge clk);
    check("R11 skip dropped", 32'h0, 1'b0, 1'b0, 3'd1, 1'b0);
    send(3'd3, 32'h0);
    check("R5 restore after skip", '1, 1'b0, 1'b0, 3'd0, 1'b0);

    // R11: jump is a single pulse
    send(3'd4, 32'h000000F0);
    send(3'd5, 32'h0);
    check("R11 jump raised", 32'h000000F0, 1'b0, 1'b1, 3'd1, 1'b0);
    @(negedge clk);
    check("R11 jump dropped", 32'h000000F0, 1'b0, 1'b0, 3'd1, 1'b0);
    send(3'd4, 32'h0);
    check("R8 loop exit", '1, 1'b1, 1'b0, 3'd0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule